// File: doc/BRIEF.md
# Scan Snapshot Neighbor Correlator

This block looks for the shift-register neighbor of one chosen bit inside a stream of N-bit scan-out snapshots. Each snapshot arrives with a valid strobe and is one clock step of the device under analysis. For a configured target bit index and a search direction, the block holds a mask of candidate neighbor positions. On each new snapshot it removes every candidate whose value in the previous snapshot does not agree with the shift relation to the target bit. Its result is hit, miss or ambiguous.

A search begins with a start pulse, which latches the target, the direction and two optional modes. The first mode handles jump cells: a comparison is made only in rounds where the cell being checked held 0 before the step. The second mode handles irregular clocking: a snapshot that leaves all involved bits unchanged is dropped. The search ends when no candidate is left, or when a parameterized number of compared rounds has been reached. It reports the outcome with a one-cycle done pulse.

Top module: `scan_nbr_search`

## Requirements
- R1: A start pulse latches the target index (which must be below N), the direction, the jump mode and the skip mode. It also loads the suspect mask with every position except the target and clears the round count. The first valid snapshot after start is stored as the reference only and prunes nothing. A snapshot presented in the same cycle as start is ignored.
- R2: Leftward mode (dir_left=1): a candidate W is removed in a compared round when bit W of the previous snapshot differs from the target bit of the current snapshot.
- R3: Rightward mode (dir_left=0): a candidate Y is removed in a compared round when the target bit of the previous snapshot differs from bit Y of the current snapshot.
- R4: Jump mode. In leftward mode a round compares only when the target bit of the previous snapshot is 0. In rightward mode candidate Y is compared only when its own bit in the previous snapshot is 0. Every candidate that is not compared is kept, and the round still counts.
- R5: If a compared round leaves the mask empty, done rises in the cycle after that snapshot's clock edge, with status 2'b10 (miss) and hit_idx 0.
- R6: If the mask is not empty after MAX_ROUNDS compared rounds and exactly one candidate remains, done rises with status 2'b01 (hit) and hit_idx set to that position.
- R7: If more than one candidate remains after MAX_ROUNDS compared rounds, done rises with status 2'b11 (ambiguous) and hit_idx set to the lowest surviving position.
- R8: Skip mode. A snapshot whose target bit and every still-suspect bit equal the reference is discarded: no pruning, no round counted, and the reference is kept.
- R9: done is high for one cycle only. status and hit_idx hold their values until the next done. Snapshots that arrive after done, and before the next start, have no effect. After reset, status is 2'b00 and hit_idx is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new search with the configuration below |
| target | input | IW | Index of the bit whose neighbor is sought |
| dir_left | input | 1 | 1 = leftward search, 0 = rightward search |
| jump_en | input | 1 | Compare only in the rounds allowed for jump cells |
| skip_en | input | 1 | Discard redundant snapshots |
| snap_valid | input | 1 | snap carries a new snapshot |
| snap | input | N | Scan-out snapshot |
| done | output | 1 | One-cycle end-of-search pulse |
| status | output | 2 | 00 none, 01 hit, 10 miss, 11 ambiguous |
| hit_idx | output | IW | Surviving index (lowest one when ambiguous) |

## Verification
The bench builds the block with N=12 and MAX_ROUNDS=6. With these values a false candidate survives all rounds by chance often enough that random runs produce hits, ambiguous results and early misses side by side. Twelve bits also leave room for an eight-stage shift register beside four noise bits, so both directions find real neighbors. The short round limit keeps each search to a few cycles, which lets many configurations, including the jump and skip modes, be tried against the bench's own model.

// File: rtl/scan_nbr_search.sv
module scan_nbr_search #(
  parameter int N          = 16,
  parameter int MAX_ROUNDS = 15,
  localparam int IW        = (N > 1) ? $clog2(N) : 1,
  localparam int RW        = $clog2(MAX_ROUNDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] target,
  input  logic          dir_left,
  input  logic          jump_en,
  input  logic          skip_en,
  input  logic          snap_valid,
  input  logic [N-1:0]  snap,
  output logic          done,
  output logic [1:0]    status,
  output logic [IW-1:0] hit_idx
);

  localparam logic [1:0] ST_HIT  = 2'b01;
  localparam logic [1:0] ST_MISS = 2'b10;
  localparam logic [1:0] ST_AMB  = 2'b11;
  localparam logic [N-1:0] ONE   = {{(N-1){1'b0}}, 1'b1};

  logic          active, have_ref, left_q, jump_q, skip_q;
  logic [IW-1:0] tgt_q;
  logic [N-1:0]  mask, ref_q;
  logic [RW-1:0] round;

  logic [N-1:0]  tsel, keep, pruned;
  logic          redundant, prune_ev, last, single;
  logic [IW-1:0] low;

  assign tsel      = ONE << tgt_q;
  assign redundant = skip_q && (((snap ^ ref_q) & (mask | tsel)) == '0);
  assign prune_ev  = active && snap_valid && !start && have_ref && !redundant;
  assign last      = (round == RW'(MAX_ROUNDS - 1));
  assign pruned    = mask & keep;
  assign single    = (pruned != '0) && ((pruned & (pruned - ONE)) == '0);

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (left_q)
        keep[i] = (jump_q && ref_q[tgt_q]) || (ref_q[i] == snap[tgt_q]);
      else
        keep[i] = (jump_q && ref_q[i]) || (ref_q[tgt_q] == snap[i]);
    end
    low = '0;
    for (int i = N - 1; i >= 0; i--)
      if (pruned[i]) low = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      have_ref <= 1'b0;
      left_q   <= 1'b0;
      jump_q   <= 1'b0;
      skip_q   <= 1'b0;
      tgt_q    <= '0;
      mask     <= '0;
      ref_q    <= '0;
      round    <= '0;
      done     <= 1'b0;
      status   <= 2'b00;
      hit_idx  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        tgt_q    <= target;
        left_q   <= dir_left;
        jump_q   <= jump_en;
        skip_q   <= skip_en;
        mask     <= ~(ONE << target);
        round    <= '0;
        have_ref <= 1'b0;
        active   <= 1'b1;
      end else if (active && snap_valid && !have_ref) begin
        ref_q    <= snap;
        have_ref <= 1'b1;
      end else if (prune_ev) begin
        mask  <= pruned;
        ref_q <= snap;
        round <= round + 1'b1;
        if (pruned == '0) begin
          done    <= 1'b1;
          status  <= ST_MISS;
          hit_idx <= '0;
          active  <= 1'b0;
        end else if (last) begin
          done    <= 1'b1;
          status  <= single ? ST_HIT : ST_AMB;
          hit_idx <= low;
          active  <= 1'b0;
        end
      end
    end
  end

endmodule

module scan_nbr_search_chk #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          active,
  input logic          done,
  input logic [1:0]    status,
  input logic [IW-1:0] hit_idx,
  input logic [IW-1:0] tgt_q,
  input logic [N-1:0]  mask
);

  // R1
  mask_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ((mask & ~$past(mask)) == '0));

  // R1
  target_excluded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !mask[tgt_q]);

  // R1
  start_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

  // R5
  miss_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'b10) |-> (mask == '0));

  // R6
  hit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'b01) |-> ($countones(mask) == 1 && mask[hit_idx]));

  // R7
  amb_multi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'b11) |-> ($countones(mask) > 1 && mask[hit_idx]));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(status));

  // R9
  done_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status != 2'b00 && !active));

endmodule

bind scan_nbr_search scan_nbr_search_chk #(.N(N), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .active(active), .done(done),
  .status(status), .hit_idx(hit_idx), .tgt_q(tgt_q), .mask(mask)
);

// File: tb/scan_nbr_search_bench.sv
module scan_nbr_search_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 12;
  localparam int MR = 6;
  localparam int IW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, dir_left = 0, jump_en = 0, skip_en = 0, snap_valid = 0;
  logic [IW-1:0] target = '0;
  logic [N-1:0] snap = '0;
  logic done;
  logic [1:0] status;
  logic [IW-1:0] hit_idx;

  always #(CLK_PERIOD / 2) clk = ~clk;

  scan_nbr_search #(.N(N), .MAX_ROUNDS(MR)) u_scan_nbr_search (
    .clk(clk), .rst_n(rst_n), .start(start), .target(target),
    .dir_left(dir_left), .jump_en(jump_en), .skip_en(skip_en),
    .snap_valid(snap_valid), .snap(snap), .done(done),
    .status(status), .hit_idx(hit_idx));

  int total = 0, fails = 0;
  logic [N-1:0] m_mask, m_ref, lfsr;
  bit m_act = 0, m_have = 0, m_left, m_jump, m_skip;
  int m_tgt, m_round;
  logic [1:0] m_st = 2'b00;
  logic [IW-1:0] m_idx = '0;

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] step_lfsr(logic [N-1:0] p);
    logic [N-1:0] n;
    n = p;
    n[0] = p[2] ^ p[7];
    for (int i = 1; i < 8; i++) n[i] = p[i-1];
    n[11:8] = 4'($urandom);
    return n;
  endfunction

  task automatic begin_search(int t, bit l, bit j, bit s, bit with_snap);
    start = 1; target = IW'(t); dir_left = l; jump_en = j; skip_en = s;
    snap_valid = with_snap; snap = N'($urandom);
    m_tgt = t; m_left = l; m_jump = j; m_skip = s;
    m_mask = ~(N'(1) << t); m_round = 0; m_have = 0; m_act = 1;
    @(negedge clk);
    start = 0; snap_valid = 0;
    check(done == 1'b0, "R1 no done on start", done, 0);
  endtask

  task automatic feed(logic [N-1:0] s, string req);
    bit exp_done = 0;
    int cnt, lo;
    snap_valid = 1; snap = s;
    if (m_act) begin
      if (!m_have) begin
        m_ref = s; m_have = 1;
      end else if (!(m_skip && (((s ^ m_ref) & (m_mask | (N'(1) << m_tgt))) == '0))) begin
        for (int i = 0; i < N; i++) begin
          bit k;
          if (m_left) k = (m_jump && m_ref[m_tgt]) || (m_ref[i] == s[m_tgt]);
          else        k = (m_jump && m_ref[i]) || (m_ref[m_tgt] == s[i]);
          if (!k) m_mask[i] = 1'b0;
        end
        m_ref = s; m_round++;
        cnt = $countones(m_mask); lo = 0;
        for (int i = N - 1; i >= 0; i--) if (m_mask[i]) lo = i;
        if (cnt == 0) begin
          exp_done = 1; m_st = 2'b10; m_idx = '0; m_act = 0;
        end else if (m_round == MR) begin
          exp_done = 1; m_st = (cnt == 1) ? 2'b01 : 2'b11; m_idx = IW'(lo); m_act = 0;
        end
      end
    end
    @(negedge clk);
    snap_valid = 0;
    check(done == exp_done, {req, " done"}, done, exp_done);
    check(status == m_st, {req, " status"}, status, m_st);
    check(hit_idx == m_idx, {req, " index"}, hit_idx, m_idx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    check(done == 0 && status == 2'b00 && hit_idx == 0, "R9 reset", status, 0);

    // R2 leftward hit on shift-register bits
    lfsr = 12'h0A5;
    begin_search(5, 1, 0, 0, 1);
    for (int k = 0; k < MR + 1; k++) begin lfsr = step_lfsr(lfsr); feed(lfsr, "R2 left"); end
    check(status != 2'b10, "R2 left not miss", status, 1);

    // R3 rightward search
    begin_search(3, 0, 0, 0, 0);
    for (int k = 0; k < MR + 1; k++) begin lfsr = step_lfsr(lfsr); feed(lfsr, "R3 right"); end

    // R5 directed miss
    begin_search(3, 1, 0, 0, 0);
    feed(12'h000, "R5 ref");
    feed(12'h008, "R5 miss");
    check(status == 2'b10 && hit_idx == 0, "R5 miss code", status, 2);
    // R9 snapshots after done ignored
    feed(12'h000, "R9 after done");
    feed(12'hFFF, "R9 after done");
    check(status == 2'b10, "R9 hold", status, 2);

    // R7 ambiguous: all survive, lowest index
    begin_search(0, 0, 0, 0, 0);
    for (int k = 0; k < MR + 1; k++) feed(12'h000, "R7 amb");
    check(status == 2'b11 && hit_idx == 1, "R7 amb code", hit_idx, 1);

    // R4 jump mode: target bit always 1 so no round compares
    begin_search(4, 1, 1, 0, 0);
    for (int k = 0; k < MR + 1; k++) feed(N'($urandom) | 12'h010, "R4 jump");
    check(status == 2'b11 && hit_idx == 0, "R4 jump keeps all", hit_idx, 0);

    // R8 redundant snapshots not counted
    begin_search(2, 1, 0, 1, 0);
    for (int k = 0; k < 3 * MR; k++) feed(12'h000, "R8 skip");
    check(done == 0, "R8 no end", done, 0);
    feed(12'h004, "R8 miss after skip");
    check(status == 2'b10, "R8 miss code", status, 2);

    // R1 restart mid-search and start with snapshot
    begin_search(6, 1, 0, 0, 0);
    feed(12'h000, "R1 first");
    feed(12'h000, "R1 second");
    begin_search(6, 1, 0, 0, 1);
    feed(12'h000, "R1 ref after restart");
    feed(12'h040, "R1 miss after restart");
    check(status == 2'b10, "R1 restart miss", status, 2);

    // random mix
    for (int s = 0; s < 60; s++) begin
      int t = $urandom_range(N - 1);
      bit l = $urandom_range(1), j = ($urandom_range(3) == 0), sk = $urandom_range(1);
      logic [N-1:0] prev;
      begin_search(t, l, j, sk, 0);
      lfsr = N'($urandom) | 12'h001;
      prev = lfsr;
      for (int k = 0; k < 3 * MR + 4; k++) begin
        if (sk && $urandom_range(3) == 0) feed(prev, "R8 random");
        else begin
          lfsr = j ? N'($urandom) : step_lfsr(lfsr);
          prev = lfsr;
          feed(lfsr, l ? (j ? "R4 random" : "R2 random") : (j ? "R4 random" : "R3 random"));
        end
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule